// File: doc/BRIEF.md
# Programmable Pin-Range Remapper

This block turns an input pin number into a downstream interrupt number. A small table of regions describes the translation. Each region is a triple: the first pin it covers, the first downstream number it produces, and how many consecutive pins it spans. Software or a configuration sequencer fills the table through a single-cycle write port. Each region slot is written as a whole triple.

A lookup presents a pin number with a request strobe. One clock later the block returns a response. The response is either a hit carrying the downstream number or a miss meaning the pin has no parent. When several regions cover the same pin, the lowest-numbered slot wins. A slot whose span is zero is treated as empty. After reset every slot is empty.

Top module: `pin_range_remap`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle in which `lk_req` was high at the rising clock edge, and low otherwise.
- R2: A pin matches a slot when pin >= first pin and pin < first pin + span. On a hit, `rsp_num` equals first downstream number + (pin - first pin), taken modulo 2^PAR_W.
- R3: When more than one slot matches, the slot with the lowest index supplies the result.
- R4: A pin that matches no slot gives `rsp_miss`=1, `rsp_hit`=0 and `rsp_num`=0.
- R5: A slot whose span is zero never matches any pin. This includes its own first pin.
- R6: A write with `cfg_we` high at a clock edge affects lookups requested at later edges. A lookup requested at the same edge as a write uses the table contents from before that write.
- R7: Reset clears all outputs to zero and empties every slot, so every lookup after reset misses until a slot is written.
- R8: `rsp_hit` and `rsp_miss` are never high together. While `rsp_valid` is low, both flags and `rsp_num` are zero.
- R9: The end of a region is compared without wrap-around. A region whose first pin + span passes 2^PIN_W still matches the top pin values and never matches small pins. Pin value 256 is a legal lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one table slot this cycle |
| cfg_idx | input | IDX_W | Slot index to write |
| cfg_pin_base | input | PIN_W | First pin covered by the slot |
| cfg_parent_base | input | PAR_W | Downstream number for the first pin |
| cfg_count | input | CNT_W | Number of consecutive pins covered (0 = empty) |
| lk_req | input | 1 | Lookup request strobe |
| lk_pin | input | PIN_W | Pin number to translate |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Pin was mapped; rsp_num is meaningful |
| rsp_miss | output | 1 | Pin has no parent |
| rsp_num | output | PAR_W | Downstream number on a hit, else zero |

## Verification
A table write and a lookup can land on the same clock edge. The bench provokes this by raising `cfg_we` and `lk_req` together, with the lookup pin inside the region being written. It then repeats the lookup on the following cycle. The first response must show the old contents (a miss), and the second must show the new mapping. A behavioural model applies writes only after it computes the lookup of that edge, and it judges every cycle, including long runs where writes and random lookups overlap.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'b00,
        RSP_HIT  = 2'b01,
        RSP_MISS = 2'b10
    } rsp_kind_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/remap_table.sv
module remap_table #(
    parameter int NUM_REGIONS = 8,
    parameter int PIN_W       = 9,
    parameter int PAR_W       = 10,
    parameter int CNT_W       = 9,
    parameter int IDX_W       = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we_i,
    input  logic [IDX_W-1:0]                    idx_i,
    input  logic [PIN_W-1:0]                    pin_base_i,
    input  logic [PAR_W-1:0]                    par_base_i,
    input  logic [CNT_W-1:0]                    count_i,
    output logic [NUM_REGIONS-1:0][PIN_W-1:0]   pin_base_o,
    output logic [NUM_REGIONS-1:0][PAR_W-1:0]   par_base_o,
    output logic [NUM_REGIONS-1:0][CNT_W-1:0]   count_o
);

    typedef struct packed {
        logic [NUM_REGIONS-1:0][PIN_W-1:0] pin_base;
        logic [NUM_REGIONS-1:0][PAR_W-1:0] par_base;
        logic [NUM_REGIONS-1:0][CNT_W-1:0] count;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (we_i && (int'(idx_i) == i)) begin
                tbl_d.pin_base[i] = pin_base_i;
                tbl_d.par_base[i] = par_base_i;
                tbl_d.count[i]    = count_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign pin_base_o = tbl_q.pin_base;
    assign par_base_o = tbl_q.par_base;
    assign count_o    = tbl_q.count;

endmodule

// File: rtl/remap_match.sv
module remap_match #(
    parameter int PIN_W = 9,
    parameter int CNT_W = 9
) (
    input  logic [PIN_W-1:0] pin_i,
    input  logic [PIN_W-1:0] base_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             hit_o
);

    // One extra bit so that base + count never wraps.
    localparam int EW = int'(remap_pkg::max_of(PIN_W, CNT_W)) + 1;

    logic [EW-1:0] pin_x;
    logic [EW-1:0] lo_x;
    logic [EW-1:0] hi_x;

    assign pin_x = EW'(pin_i);
    assign lo_x  = EW'(base_i);
    assign hi_x  = lo_x + EW'(count_i);

    assign hit_o = (count_i != '0) && (pin_x >= lo_x) && (pin_x < hi_x);

endmodule

// File: rtl/remap_select.sv
module remap_select #(
    parameter int NUM_REGIONS = 8,
    parameter int PIN_W       = 9,
    parameter int PAR_W       = 10,
    parameter int IDX_W       = 3
) (
    input  logic [NUM_REGIONS-1:0]              hit_vec_i,
    input  logic [NUM_REGIONS-1:0][PIN_W-1:0]   pin_base_i,
    input  logic [NUM_REGIONS-1:0][PAR_W-1:0]   par_base_i,
    input  logic [PIN_W-1:0]                    pin_i,
    output logic                                any_o,
    output logic [PAR_W-1:0]                    num_o
);

    localparam int SUM_W = int'(remap_pkg::max_of(PIN_W, PAR_W));

    logic [IDX_W-1:0] sel_idx;
    logic [SUM_W-1:0] offset;
    logic [SUM_W-1:0] total;

    // Walk from the top so the lowest matching index is left standing.
    always_comb begin
        any_o   = 1'b0;
        sel_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec_i[i]) begin
                any_o   = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    assign offset = SUM_W'(pin_i) - SUM_W'(pin_base_i[sel_idx]);
    assign total  = SUM_W'(par_base_i[sel_idx]) + offset;
    assign num_o  = any_o ? PAR_W'(total) : '0;

endmodule

// File: rtl/pin_range_remap.sv
module pin_range_remap #(
    parameter int NUM_REGIONS = 8,
    parameter int PIN_W       = 9,
    parameter int PAR_W       = 10,
    parameter int CNT_W       = 9,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [PIN_W-1:0] cfg_pin_base,
    input  logic [PAR_W-1:0] cfg_parent_base,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             lk_req,
    input  logic [PIN_W-1:0] lk_pin,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [PAR_W-1:0] rsp_num
);

    import remap_pkg::*;

    typedef struct packed {
        rsp_kind_e        kind;
        logic [PAR_W-1:0] num;
    } rsp_t;

    logic [NUM_REGIONS-1:0][PIN_W-1:0] tbl_pin_base;
    logic [NUM_REGIONS-1:0][PAR_W-1:0] tbl_par_base;
    logic [NUM_REGIONS-1:0][CNT_W-1:0] tbl_count;
    logic [NUM_REGIONS-1:0]            hit_vec;
    logic                              any_hit;
    logic [PAR_W-1:0]                  mapped_num;

    rsp_t rsp_d, rsp_q;

    remap_table #(
        .NUM_REGIONS (NUM_REGIONS),
        .PIN_W       (PIN_W),
        .PAR_W       (PAR_W),
        .CNT_W       (CNT_W),
        .IDX_W       (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we),
        .idx_i      (cfg_idx),
        .pin_base_i (cfg_pin_base),
        .par_base_i (cfg_parent_base),
        .count_i    (cfg_count),
        .pin_base_o (tbl_pin_base),
        .par_base_o (tbl_par_base),
        .count_o    (tbl_count)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        remap_match #(
            .PIN_W (PIN_W),
            .CNT_W (CNT_W)
        ) u_match (
            .pin_i   (lk_pin),
            .base_i  (tbl_pin_base[g]),
            .count_i (tbl_count[g]),
            .hit_o   (hit_vec[g])
        );
    end

    remap_select #(
        .NUM_REGIONS (NUM_REGIONS),
        .PIN_W       (PIN_W),
        .PAR_W       (PAR_W),
        .IDX_W       (IDX_W)
    ) u_select (
        .hit_vec_i  (hit_vec),
        .pin_base_i (tbl_pin_base),
        .par_base_i (tbl_par_base),
        .pin_i      (lk_pin),
        .any_o      (any_hit),
        .num_o      (mapped_num)
    );

    always_comb begin
        rsp_d = '0;
        if (lk_req) begin
            if (any_hit) begin
                rsp_d.kind = RSP_HIT;
                rsp_d.num  = mapped_num;
            end else begin
                rsp_d.kind = RSP_MISS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = (rsp_q.kind != RSP_IDLE);
    assign rsp_hit   = (rsp_q.kind == RSP_HIT);
    assign rsp_miss  = (rsp_q.kind == RSP_MISS);
    assign rsp_num   = rsp_q.num;

endmodule

// File: rtl/remap_checker.sv
module remap_checker #(
    parameter int PAR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [PAR_W-1:0] rsp_num
);

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    a_r1_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    a_r8_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_num == '0));

    a_r4_miss_num_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_num == '0));

endmodule

bind pin_range_remap remap_checker #(.PAR_W(PAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_num   (rsp_num)
);

// File: tb/pin_range_remap_tb.sv
`timescale 1ns/1ps
module pin_range_remap_tb;

    localparam int NR    = 8;
    localparam int PIN_W = 9;
    localparam int PAR_W = 10;
    localparam int CNT_W = 9;
    localparam int IDX_W = 3;
    localparam int PMASK = (1 << PAR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [PIN_W-1:0] cfg_pin_base = '0;
    logic [PAR_W-1:0] cfg_parent_base = '0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic             lk_req = 1'b0;
    logic [PIN_W-1:0] lk_pin = '0;
    logic             rsp_valid, rsp_hit, rsp_miss;
    logic [PAR_W-1:0] rsp_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_range_remap #(
        .NUM_REGIONS (NR),
        .PIN_W       (PIN_W),
        .PAR_W       (PAR_W),
        .CNT_W       (CNT_W)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_idx         (cfg_idx),
        .cfg_pin_base    (cfg_pin_base),
        .cfg_parent_base (cfg_parent_base),
        .cfg_count       (cfg_count),
        .lk_req          (lk_req),
        .lk_pin          (lk_pin),
        .rsp_valid       (rsp_valid),
        .rsp_hit         (rsp_hit),
        .rsp_miss        (rsp_miss),
        .rsp_num         (rsp_num)
    );

    // Behavioural model
    int m_base [NR];
    int m_par  [NR];
    int m_cnt  [NR];
    bit e_valid, e_hit, e_miss;
    int e_num;

    function automatic void model_lookup(input int pin, output bit hit, output int num);
        hit = 1'b0;
        num = 0;
        for (int i = 0; i < NR; i++) begin
            if (!hit && m_cnt[i] != 0 && pin >= m_base[i] && pin < m_base[i] + m_cnt[i]) begin
                hit = 1'b1;
                num = (m_par[i] + pin - m_base[i]) & PMASK;
            end
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                m_base[i] = 0; m_par[i] = 0; m_cnt[i] = 0;
            end
            e_valid = 0; e_hit = 0; e_miss = 0; e_num = 0;
        end else begin
            bit h;
            int n;
            model_lookup(int'(lk_pin), h, n);
            e_valid = lk_req;
            e_hit   = lk_req && h;
            e_miss  = lk_req && !h;
            e_num   = (lk_req && h) ? n : 0;
            if (cfg_we) begin
                m_base[cfg_idx] = int'(cfg_pin_base);
                m_par[cfg_idx]  = int'(cfg_parent_base);
                m_cnt[cfg_idx]  = int'(cfg_count);
            end
        end
        #2;
        if (!done) begin
            string tag;
            tag = (rsp_valid !== e_valid) ? "R1" : (e_miss ? "R4" : (e_hit ? "R2" : "R8"));
            check(rsp_valid === e_valid && rsp_hit === e_hit && rsp_miss === e_miss
                  && int'(rsp_num) == e_num && !$isunknown(rsp_num),
                  {tag, " model"},
                  $sformatf("v%0b h%0b m%0b n%0d", rsp_valid, rsp_hit, rsp_miss, rsp_num),
                  $sformatf("v%0b h%0b m%0b n%0d", e_valid, e_hit, e_miss, e_num));
        end
    end

    task automatic wr(input int idx, input int base, input int par, input int cnt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_pin_base = PIN_W'(base);
        cfg_parent_base = PAR_W'(par); cfg_count = CNT_W'(cnt);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input int pin, input bit exp_hit, input int exp_num, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_pin = PIN_W'(pin);
        @(negedge clk);
        lk_req = 1'b0;
        check(rsp_valid === 1'b1 && rsp_hit === exp_hit && rsp_miss === !exp_hit
              && int'(rsp_num) == exp_num, tag,
              $sformatf("pin%0d v%0b h%0b n%0d", pin, rsp_valid, rsp_hit, rsp_num),
              $sformatf("pin%0d v1 h%0b n%0d", pin, exp_hit, exp_num));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid === 0 && rsp_hit === 0 && rsp_miss === 0 && rsp_num === '0, "R7 reset outputs",
              $sformatf("v%0b h%0b m%0b n%0d", rsp_valid, rsp_hit, rsp_miss, rsp_num), "all zero");
        rst_n = 1'b1;
        look(0, 0, 0, "R7 empty after reset");
        look(256, 0, 0, "R7 empty table top pin");

        wr(0, 10, 100, 5);
        look(9, 0, 0, "R2 below base");
        look(10, 1, 100, "R2 first pin");
        look(14, 1, 104, "R2 last pin");
        look(15, 0, 0, "R4 one past end");

        wr(1, 12, 300, 10);
        look(13, 1, 103, "R3 overlap lowest slot wins");
        look(16, 1, 304, "R3 second slot beyond first");

        wr(2, 40, 600, 0);
        look(40, 0, 0, "R5 zero span own base");

        // Write and lookup on the same edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd3; cfg_pin_base = 9'd50; cfg_parent_base = 10'd7; cfg_count = 9'd4;
        lk_req = 1'b1; lk_pin = 9'd50;
        @(negedge clk);
        cfg_we = 1'b0; lk_req = 1'b0;
        check(rsp_valid === 1 && rsp_miss === 1 && rsp_hit === 0, "R6 same-edge lookup sees old table",
              $sformatf("h%0b m%0b", rsp_hit, rsp_miss), "h0 m1");
        look(50, 1, 7, "R6 next lookup sees write");

        wr(4, 500, 1020, 20);
        look(511, 1, 7, "R9 no wrap top pin");
        look(3, 0, 0, "R9 no wrap small pin");
        wr(5, 250, 0, 7);
        look(256, 1, 6, "R9 pin 256");

        wr(0, 10, 100, 0);
        look(10, 0, 0, "R5 slot emptied by rewrite");
        look(13, 1, 301, "R3 next slot takes over");

        // Back-to-back random traffic, judged by the model every cycle (R1, R6)
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            lk_req = ($urandom_range(0, 3) != 0);
            lk_pin = PIN_W'($urandom_range(0, 300));
            cfg_we = ($urandom_range(0, 7) == 0);
            cfg_idx = IDX_W'($urandom_range(0, NR - 1));
            cfg_pin_base = PIN_W'($urandom_range(0, 280));
            cfg_parent_base = PAR_W'($urandom_range(0, 1023));
            cfg_count = CNT_W'($urandom_range(0, 40));
        end
        @(negedge clk);
        lk_req = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        check(rsp_valid === 0 && rsp_hit === 0 && rsp_miss === 0 && rsp_num === '0, "R8 idle after traffic",
              $sformatf("v%0b h%0b m%0b n%0d", rsp_valid, rsp_hit, rsp_miss, rsp_num), "all zero");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule